// File: doc/BRIEF.md
# Fixed-Priority Token Merge Selector

This block lets several token-holding pipeline stages compete for a single downstream stage. Every source presents a one-bit token, meaning "I hold work", together with a record of side information. In the same cycle, the selector forwards the token and record of the best-ranked occupied source to its output. It also returns a per-source Used flag.

The Used flag tells a source that it has been picked this cycle. A source frees its slot only when its Used flag is 1 and its own downstream-stall input is 0. A picked source therefore still keeps its token while the target stalls, and a source that was not picked always keeps it. The stall path from the target back to the sources is wired outside the selector. The selector itself is purely combinational and stores nothing.

The ranking is fixed: input 0 is the strongest, then input 1, and so on. Two equivalent grant structures can be chosen by parameter: a ripple chain or a two's-complement lowest-set-bit isolate.

Top module: `tok_merge_sel`

## Requirements
- R1: `tgt_tok` is 1 exactly when at least one bit of `src_tok` is 1, in the same cycle, with no register on the path.
- R2: Ranking is strict, with index 0 highest. Input k is selected only when `src_tok[k]` is 1 and every `src_tok[j]` with j < k is 0.
- R3: `src_used` has at most one bit set, and that bit is the index of the selected input.
- R4: `tgt_rec` equals the record of the selected input, taken from bits `[k*REC_W +: REC_W]` of `src_rec`, in the same cycle.
- R5: When no token is present, `tgt_tok` is 0 and all `src_used` bits are 0. `tgt_rec` is then unspecified; this design drives it to 0.
- R6: A `src_used` bit is never 1 for an input whose token is 0.
- R7: When two occupied source stages feed an accepting target through the block, exactly one token moves per cycle, in rank order, and its record arrives with it.
- R8: While the target stage is full and stalled, the selected source sees Used = 1 and still keeps its token. The unselected source also keeps its token. After the stall ends, the tokens move in rank order.
- R9: `NUM_SRC` (at least 2) and `REC_W` (at least 1) are parameters, checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_tok | input | NUM_SRC | Token presence per source, bit 0 ranked highest |
| src_rec | input | NUM_SRC*REC_W | Packed source records, source k at bits [k*REC_W +: REC_W] |
| tgt_tok | output | 1 | Token forwarded to the target |
| tgt_rec | output | REC_W | Record of the forwarded token |
| src_used | output | NUM_SRC | One-hot Used flag for the selected source |

## Verification
The assertions assume the inputs are settled values when they are evaluated. They relate the grant vector, the token inputs and the muxed record in the same cycle. They take no account of time, because the block holds nothing between cycles.

The stimulus respects this. All direct token and record patterns are applied away from the clock edge and read back after settling. In the staged scenarios, the source stages change only on a clock edge, and their release rule combines Used with the target's stall exactly as a real neighbour would.

// File: rtl/merge_pkg.sv
package merge_pkg;
   typedef enum int {
      GRANT_RIPPLE  = 0,
      GRANT_ISOLATE = 1
   } grant_style_e;
endpackage

// File: rtl/tok_prio_grant.sv
module tok_prio_grant #(
   parameter int                     NUM_SRC     = 3,
   parameter merge_pkg::grant_style_e GRANT_STYLE = merge_pkg::GRANT_RIPPLE
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic [NUM_SRC-1:0] gnt_o
);
   localparam logic [NUM_SRC-1:0] LSB_ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

   if (GRANT_STYLE == merge_pkg::GRANT_RIPPLE) begin : g_ripple
      logic [NUM_SRC:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         assign gnt_o[i]    = req_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | req_i[i];
      end
   end else begin : g_isolate
      assign gnt_o = req_i & (~req_i + LSB_ONE);
   end

   always_comb begin
      AST_GNT_ONEHOT: assert ($onehot0(gnt_o)) else $error("grant not one-hot"); // R3
      AST_GNT_SUBSET: assert ((gnt_o & ~req_i) == '0) else $error("grant without token"); // R6
      AST_GNT_ANY: assert ((|gnt_o) == (|req_i)) else $error("grant presence mismatch"); // R1
      AST_GNT_RANK: assert ((gnt_o == '0) || ((req_i & (gnt_o - LSB_ONE)) == '0)) else $error("higher rank skipped"); // R2
   end
endmodule

// File: rtl/tok_rec_mux.sv
module tok_rec_mux #(
   parameter int NUM_SRC = 3,
   parameter int REC_W   = 8
) (
   input  logic [NUM_SRC-1:0]       sel_i,
   input  logic [NUM_SRC*REC_W-1:0] rec_i,
   output logic [REC_W-1:0]         rec_o
);
   logic [REC_W-1:0] part [NUM_SRC+1];

   assign part[0] = '0;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_or
      assign part[i+1] = part[i] | (rec_i[i*REC_W +: REC_W] & {REC_W{sel_i[i]}});
   end
   assign rec_o = part[NUM_SRC];
endmodule

// File: rtl/tok_merge_sel.sv
module tok_merge_sel #(
   parameter int                     NUM_SRC     = 3,
   parameter int                     REC_W       = 8,
   parameter merge_pkg::grant_style_e GRANT_STYLE = merge_pkg::GRANT_RIPPLE
) (
   input  logic [NUM_SRC-1:0]       src_tok,
   input  logic [NUM_SRC*REC_W-1:0] src_rec,
   output logic                     tgt_tok,
   output logic [REC_W-1:0]         tgt_rec,
   output logic [NUM_SRC-1:0]       src_used
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("tok_merge_sel: NUM_SRC must be at least 2"); // R9
   end
   if (REC_W < 1) begin : g_bad_rec
      $error("tok_merge_sel: REC_W must be at least 1"); // R9
   end

   logic [NUM_SRC-1:0] gnt;

   tok_prio_grant #(.NUM_SRC(NUM_SRC), .GRANT_STYLE(GRANT_STYLE)) u_grant (
      .req_i (src_tok),
      .gnt_o (gnt)
   );

   tok_rec_mux #(.NUM_SRC(NUM_SRC), .REC_W(REC_W)) u_mux (
      .sel_i (gnt),
      .rec_i (src_rec),
      .rec_o (tgt_rec)
   );

   assign src_used = gnt;
   assign tgt_tok  = |gnt;

   always_comb begin
      AST_IDLE_QUIET: assert ((src_tok != '0) || (!tgt_tok && src_used == '0)) else $error("output active while idle"); // R5
      for (int i = 0; i < NUM_SRC; i++) begin
         AST_REC_FOLLOWS: assert (!src_used[i] || tgt_rec == src_rec[i*REC_W +: REC_W]) else $error("record mismatch"); // R4
      end
   end
endmodule

// File: tb/tok_merge_sel_tb.sv
module tb_stage #(parameter int W = 8) (
   input  logic         clk,
   input  logic         rst,
   input  logic         x_tok,
   input  logic [W-1:0] x_rec,
   input  logic         dse,
   input  logic         used,
   output logic         y_tok,
   output logic [W-1:0] y_rec,
   output logic         wec
);
   assign wec = y_tok & (dse | ~used);
   always_ff @(posedge clk) begin
      if (rst) begin
         y_tok <= 1'b0;
         y_rec <= '0;
      end else if (!wec) begin
         y_tok <= x_tok;
         y_rec <= x_rec;
      end
   end
endmodule

module tok_merge_sel_tb;
   localparam int N = 3;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic         direct = 1'b1;
   logic [N-1:0] d_tok  = '0;
   logic [N*W-1:0] d_rec = '0;
   logic ld_a = 0, ld_b = 0, stall = 0;
   logic [W-1:0] ld_a_rec = '0, ld_b_rec = '0;

   logic a_tok, b_tok, t_tok, a_wec, b_wec, t_wec;
   logic [W-1:0] a_rec, b_rec, t_rec;

   logic [N-1:0]   dut_tok;
   logic [N*W-1:0] dut_rec;
   logic           y_tok;
   logic [W-1:0]   y_rec;
   logic [N-1:0]   used;

   assign dut_tok = direct ? d_tok : {d_tok[2], b_tok, a_tok};
   assign dut_rec = direct ? d_rec : {d_rec[3*W-1:2*W], b_rec, a_rec};

   tok_merge_sel #(.NUM_SRC(N), .REC_W(W)) u_dut (
      .src_tok(dut_tok), .src_rec(dut_rec),
      .tgt_tok(y_tok), .tgt_rec(y_rec), .src_used(used)
   );

   tb_stage #(.W(W)) u_src_a (.clk(clk), .rst(rst), .x_tok(ld_a), .x_rec(ld_a_rec),
      .dse(t_wec), .used(used[0]), .y_tok(a_tok), .y_rec(a_rec), .wec(a_wec));
   tb_stage #(.W(W)) u_src_b (.clk(clk), .rst(rst), .x_tok(ld_b), .x_rec(ld_b_rec),
      .dse(t_wec), .used(used[1]), .y_tok(b_tok), .y_rec(b_rec), .wec(b_wec));
   tb_stage #(.W(W)) u_tgt (.clk(clk), .rst(rst), .x_tok(y_tok), .x_rec(y_rec),
      .dse(stall), .used(1'b1), .y_tok(t_tok), .y_rec(t_rec), .wec(t_wec));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [N-1:0] t, input logic [N-1:0] exp_used);
      d_tok = t;
      #1;
      chk("R1 token out", {31'b0, y_tok}, {31'b0, t != '0});
      chk("R2/R3 used", {29'b0, used}, {29'b0, exp_used});
      chk("R6 used subset", {29'b0, used & ~t}, 32'h0);
      if (exp_used != '0) begin
         for (int k = 0; k < N; k++)
            if (exp_used[k]) chk("R4 record", {24'b0, y_rec}, {24'b0, d_rec[k*W +: W]});
      end
   endtask

   task automatic t_reset_idle;
      @(negedge clk);
      chk("R5 reset target empty", {31'b0, t_tok}, 32'h0);
      apply(3'b000, 3'b000);
      chk("R5 idle used", {29'b0, used}, 32'h0);
   endtask

   task automatic t_priority;
      d_rec = {8'hC3, 8'hB2, 8'hA1};
      apply(3'b001, 3'b001);
      apply(3'b010, 3'b010);
      apply(3'b100, 3'b100);
      apply(3'b111, 3'b001);
      apply(3'b110, 3'b010);
      apply(3'b101, 3'b001);
      apply(3'b011, 3'b001);
      d_rec = {8'h5A, 8'h00, 8'hFF};
      apply(3'b110, 3'b010);
      apply(3'b100, 3'b100);
      apply(3'b000, 3'b000);
   endtask

   task automatic t_merge_flow;
      direct = 0; d_tok = '0; stall = 0;
      repeat (2) @(negedge clk);
      ld_a = 1; ld_a_rec = 8'h11; ld_b = 1; ld_b_rec = 8'h22;
      @(negedge clk);
      ld_a = 0; ld_b = 0;
      chk("R7 A picked first", {29'b0, used}, 32'h1);
      @(negedge clk);
      chk("R7 target got A", {23'b0, t_tok, t_rec}, 32'h111);
      chk("R7 A released", {31'b0, a_tok}, 32'h0);
      chk("R7 B waits", {31'b0, b_tok}, 32'h1);
      @(negedge clk);
      chk("R7 target got B", {23'b0, t_tok, t_rec}, 32'h122);
      chk("R7 B released", {31'b0, b_tok}, 32'h0);
      @(negedge clk);
      chk("R7 target drained", {31'b0, t_tok}, 32'h0);
   endtask

   task automatic t_stall_hold;
      stall = 1; ld_a = 1; ld_a_rec = 8'h33;
      @(negedge clk);
      ld_a = 0;
      @(negedge clk);
      chk("R8 target filled", {23'b0, t_tok, t_rec}, 32'h133);
      ld_a = 1; ld_a_rec = 8'h44; ld_b = 1; ld_b_rec = 8'h55;
      @(negedge clk);
      ld_a = 0; ld_b = 0;
      for (int c = 0; c < 3; c++) begin
         chk("R8 A used while stalled", {29'b0, used}, 32'h1);
         chk("R8 A holds", {23'b0, a_tok, a_rec}, 32'h144);
         chk("R8 B holds", {23'b0, b_tok, b_rec}, 32'h155);
         chk("R8 target holds", {23'b0, t_tok, t_rec}, 32'h133);
         @(negedge clk);
      end
      stall = 0;
      @(negedge clk);
      chk("R8 A moves after stall", {23'b0, t_tok, t_rec}, 32'h144);
      chk("R8 B still waits", {31'b0, b_tok}, 32'h1);
      @(negedge clk);
      chk("R8 B moves next", {23'b0, t_tok, t_rec}, 32'h155);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;
      t_reset_idle();
      t_priority();
      t_merge_flow();
      t_stall_hold();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R7 watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule